// File: doc/BRIEF.md
# MDIO Management Register File for a 10/100 PHY

This block is the management slave of a 10/100 Ethernet PHY. A station manager clocks serial command frames in on MDC over a shared, bidirectional MDIO line. Each frame either writes one 16-bit register or reads one back. A frame is acted on only when its PHY address field equals the address strapped on `phy_addr_i`. The registers hold the PHY's configuration: speed, duplex and negotiation enable, loopback, power control, coding and scrambler bypass, and the advertised abilities. They also report live link and negotiation status and the link partner's abilities, which the rest of the PHY supplies.

MDC may be unrelated to the PHY's data clocks. Both MDC and MDIO are therefore resynchronised to the block clock `clk_i`, and MDC edges are found by edge detection. Each register bit follows its own rule. A software reset clears itself. A remote-fault flag clears when its own register is read. A page-received flag clears when a different register, the partner ability register, is read. A key bit in the configuration register unlocks a small window of vendor registers.

Top module: `mdio_mgmt_regs`

## Requirements
- R1: A frame whose PHY address field differs from `phy_addr_i` changes no register, and during its read phase `mdio_oe_o` stays low.
- R2: A frame is accepted only after at least 32 consecutive preamble ones, then start bits 0,1. The opcode is 10 for a read and 01 for a write, followed by the 5-bit PHY address and the 5-bit register address. All fields are sent MSB first. For a write, two turnaround bits then 16 data bits follow, MSB first.
- R3: On a matching read, MDIO is released during the first turnaround bit and driven 0 during the second. The 16 data bits then follow MSB first, each driven after the MDC falling edge. MDIO is released again after the last data bit.
- R4: Writing 1 to bit 15 of register 0 returns every register to its reset value and raises `soft_rst_o` for exactly one clock. Bit 15 reads back as 0.
- R5: Register 0 resets to 0x3100. Its writable bits are 14 (loopback, `loopback_o`), 13 (speed 100), 12 (negotiation enable, `an_en_o`), 11 (power down, `power_down_o`) and 8 (full duplex). All other bits read 0.
- R6: While register 0 bit 12 is 1, `force_100_o` and `force_full_o` are 0. While bit 12 is 0, they follow bits 13 and 8.
- R7: Register 1 reads bits 14:11 = 1111 and bit 0 = 1. Bit 5 shows `an_done_i` and bit 2 shows `link_up_i`. Bit 4 is set by a pulse on `rfault_set_i` and clears when register 1 is read.
- R8: Register 4 resets to 0x01E1 and drives `adv_o`. Only bits 13, 10 and 8:0 are writable. Bits 15, 14 and 9 always read 0.
- R9: Register 5 returns `lp_ability_i`. In register 6, bit 0 shows `lp_an_able_i`, and bit 1 is set by a pulse on `page_rx_set_i`. Bit 1 clears when register 5 is read, and reads of any other register leave it set.
- R10: Register 17 resets to 0. Its writable bits are 15 (`rptr_o`), 14 (`bypass_4b5b_o`), 13 (`bypass_scr_o`), 12 (`ldps_o`), 11 (`analog_off_o`), 9:8 (`lb_mode_o`: 00 normal, 01 PHY loopback, 10 twisted-pair loopback) and 0 (key). All other bits read 0.
- R11: Registers 20 to 24 are 16-bit read/write only while register 17 bit 0 is 1. While the key is 0 they read 0 and ignore writes, but keep their contents.
- R12: Registers 2 and 3 return the identifier parameters. Reads of any unimplemented address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mdc_i | input | 1 | Management clock from the station manager |
| mdio_i | input | 1 | MDIO line as seen at the pad |
| mdio_o | output | 1 | MDIO drive value |
| mdio_oe_o | output | 1 | MDIO output enable |
| phy_addr_i | input | 5 | Strapped PHY address |
| link_up_i | input | 1 | Live link status |
| an_done_i | input | 1 | Negotiation complete |
| rfault_set_i | input | 1 | Pulse: remote fault detected |
| page_rx_set_i | input | 1 | Pulse: new partner page received |
| lp_an_able_i | input | 1 | Partner supports negotiation |
| lp_ability_i | input | 16 | Partner ability word |
| soft_rst_o | output | 1 | One-clock software reset pulse |
| loopback_o | output | 1 | Data loopback enable |
| an_en_o | output | 1 | Negotiation enable |
| force_100_o | output | 1 | Forced 100 Mb/s when negotiation is off |
| force_full_o | output | 1 | Forced full duplex when negotiation is off |
| power_down_o | output | 1 | Power down |
| adv_o | output | 16 | Advertised ability word |
| rptr_o | output | 1 | Repeater mode |
| bypass_4b5b_o | output | 1 | Code-group bypass |
| bypass_scr_o | output | 1 | Scrambler bypass |
| ldps_o | output | 1 | Link-down power saving |
| analog_off_o | output | 1 | Analog power-off |
| lb_mode_o | output | 2 | Loopback mode select |

## Verification
The frames used are complete writes and reads at the strapped address, the same frames at a foreign address, and a frame with a preamble that is too short. Together they separate address filtering and preamble qualification from the command decode. Writes of all ones and all zeros to each register show which bits are writable and which always read 0. Reads of register 1 repeated back to back, and of registers 6 and 5 in both orders, show which read clears which flag. Vendor-window writes made before and after toggling the key show both the gating and that locked contents are kept.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned DW = 16;
  localparam int unsigned AW = 5;

  typedef enum logic [2:0] {
    F_PRE, F_ST, F_HDR, F_TAW, F_WDAT, F_RD
  } frame_st_e;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  localparam logic [AW-1:0] A_CTRL = 5'd0;
  localparam logic [AW-1:0] A_STAT = 5'd1;
  localparam logic [AW-1:0] A_ID1  = 5'd2;
  localparam logic [AW-1:0] A_ID2  = 5'd3;
  localparam logic [AW-1:0] A_ADV  = 5'd4;
  localparam logic [AW-1:0] A_LPA  = 5'd5;
  localparam logic [AW-1:0] A_EXP  = 5'd6;
  localparam logic [AW-1:0] A_CFG  = 5'd17;
  localparam logic [AW-1:0] A_VND0 = 5'd20;

  localparam logic [DW-1:0] CTRL_RST   = 16'h3100;
  localparam logic [DW-1:0] CTRL_WMASK = 16'h7900;
  localparam logic [DW-1:0] ADV_RST    = 16'h01E1;
  localparam logic [DW-1:0] ADV_WMASK  = 16'h25FF;
  localparam logic [DW-1:0] CFG_WMASK  = 16'hFB01;
endpackage

// File: rtl/mdio_sync.sv
module mdio_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mdc_i,
  input  logic mdio_i,
  output logic rise_o,
  output logic fall_o,
  output logic dat_o
);
  logic [STAGES-1:0] mdc_s, dat_s;
  logic              mdc_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mdc_s <= '0;
      dat_s <= '1;
      mdc_d <= 1'b0;
    end else begin
      mdc_s <= {mdc_s[STAGES-2:0], mdc_i};
      dat_s <= {dat_s[STAGES-2:0], mdio_i};
      mdc_d <= mdc_s[STAGES-1];
    end
  end

  assign rise_o = mdc_s[STAGES-1] & ~mdc_d;
  assign fall_o = ~mdc_s[STAGES-1] & mdc_d;
  assign dat_o  = dat_s[STAGES-1];
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
#(
  parameter int unsigned PRE_LEN = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          dat_i,
  input  logic [AW-1:0] phy_addr_i,
  input  logic [DW-1:0] rdata_i,
  output logic          rd_stb_o,
  output logic          wr_stb_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          mdio_o,
  output logic          mdio_oe_o
);
  localparam int unsigned PCW = $clog2(PRE_LEN + 1);
  localparam int unsigned HW  = 2 + 2 * AW;

  frame_st_e      st;
  logic [PCW-1:0] pre_cnt;
  logic [4:0]     cnt;
  logic [HW-1:0]  hdr;
  logic [DW-1:0]  wsh, tsh;
  logic [AW-1:0]  reg_q;
  logic           oe_q, dout_q;

  logic [HW-1:0] hdr_nx;
  logic          hdr_done, hit;
  logic [1:0]    op_nx;

  assign hdr_nx   = {hdr[HW-2:0], dat_i};
  assign op_nx    = hdr_nx[HW-1 -: 2];
  assign hit      = (hdr_nx[2*AW-1 -: AW] == phy_addr_i);
  assign hdr_done = (st == F_HDR) && rise_i && (cnt == 5'(HW - 1));

  assign rd_stb_o = hdr_done && hit && (op_nx == OP_RD);
  assign wr_stb_o = (st == F_WDAT) && rise_i && (cnt == 5'(DW - 1));
  assign addr_o   = (st == F_HDR) ? hdr_nx[AW-1:0] : reg_q;
  assign wdata_o  = {wsh[DW-2:0], dat_i};
  assign mdio_o   = dout_q;
  assign mdio_oe_o = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st      <= F_PRE;
      pre_cnt <= '0;
      cnt     <= '0;
      hdr     <= '0;
      wsh     <= '0;
      tsh     <= '0;
      reg_q   <= '0;
      oe_q    <= 1'b0;
      dout_q  <= 1'b1;
    end else begin
      unique case (st)
        F_PRE: if (rise_i) begin
          if (dat_i) begin
            if (pre_cnt != PCW'(PRE_LEN)) pre_cnt <= pre_cnt + 1'b1;
          end else begin
            if (pre_cnt == PCW'(PRE_LEN)) st <= F_ST;
            pre_cnt <= '0;
          end
        end
        F_ST: if (rise_i) begin
          cnt <= '0;
          st  <= dat_i ? F_HDR : F_PRE;
        end
        F_HDR: if (rise_i) begin
          hdr <= hdr_nx;
          cnt <= cnt + 1'b1;
          if (hdr_done) begin
            cnt   <= '0;
            reg_q <= hdr_nx[AW-1:0];
            if (hit && op_nx == OP_RD) begin
              st  <= F_RD;
              tsh <= rdata_i;
            end else if (hit && op_nx == OP_WR) begin
              st <= F_TAW;
            end else begin
              st <= F_PRE;
            end
          end
        end
        F_TAW: if (rise_i) begin
          cnt <= cnt + 1'b1;
          if (cnt == 5'd1) begin
            cnt <= '0;
            st  <= F_WDAT;
          end
        end
        F_WDAT: if (rise_i) begin
          wsh <= wdata_o;
          cnt <= cnt + 1'b1;
          if (wr_stb_o) begin
            cnt <= '0;
            st  <= F_PRE;
          end
        end
        F_RD: if (fall_i) begin
          cnt <= cnt + 1'b1;
          if (cnt == 5'd1) begin
            oe_q   <= 1'b1;   // second turnaround bit: drive 0
            dout_q <= 1'b0;
          end else if (cnt >= 5'd2 && cnt <= 5'(DW + 1)) begin
            dout_q <= tsh[DW-1];
            tsh    <= {tsh[DW-2:0], 1'b0};
          end else if (cnt == 5'(DW + 2)) begin
            oe_q   <= 1'b0;
            dout_q <= 1'b1;
            cnt    <= '0;
            st     <= F_PRE;
          end
        end
        default: st <= F_PRE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter logic [DW-1:0] ID1   = 16'h00A5,
  parameter logic [DW-1:0] ID2   = 16'h5C10,
  parameter int unsigned   VND_N = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_stb_i,
  input  logic          wr_stb_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          link_up_i,
  input  logic          an_done_i,
  input  logic          rfault_set_i,
  input  logic          page_rx_set_i,
  input  logic          lp_an_able_i,
  input  logic [DW-1:0] lp_ability_i,
  output logic          soft_rst_o,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] adv_o,
  output logic [DW-1:0] cfg_o
);
  logic [DW-1:0] ctrl_q, adv_q, cfg_q;
  logic          rf_q, pg_q, srst_q;
  logic          do_srst, key;
  logic [DW*VND_N-1:0] vnd_bus;
  logic          vnd_hit;
  logic [AW-1:0] vidx;

  assign do_srst = wr_stb_i && (addr_i == A_CTRL) && wdata_i[DW-1];
  assign key     = cfg_q[0];
  assign vidx    = addr_i - A_VND0;
  assign vnd_hit = (int'(addr_i) >= int'(A_VND0)) &&
                   (int'(addr_i) <  int'(A_VND0) + int'(VND_N));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      adv_q  <= ADV_RST;
      cfg_q  <= '0;
      rf_q   <= 1'b0;
      pg_q   <= 1'b0;
      srst_q <= 1'b0;
    end else if (do_srst) begin
      ctrl_q <= CTRL_RST;
      adv_q  <= ADV_RST;
      cfg_q  <= '0;
      rf_q   <= 1'b0;
      pg_q   <= 1'b0;
      srst_q <= 1'b1;
    end else begin
      srst_q <= 1'b0;
      if (wr_stb_i) begin
        unique case (addr_i)
          A_CTRL:  ctrl_q <= wdata_i & CTRL_WMASK;
          A_ADV:   adv_q  <= wdata_i & ADV_WMASK;
          A_CFG:   cfg_q  <= wdata_i & CFG_WMASK;
          default: ;
        endcase
      end
      // a set event in the same cycle as a clearing read wins
      if (rfault_set_i)                        rf_q <= 1'b1;
      else if (rd_stb_i && addr_i == A_STAT)   rf_q <= 1'b0;
      if (page_rx_set_i)                       pg_q <= 1'b1;
      else if (rd_stb_i && addr_i == A_LPA)    pg_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < VND_N; i++) begin : g_vnd
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 q <= '0;
      else if (do_srst)            q <= '0;
      else if (wr_stb_i && key && vnd_hit && vidx == AW'(i)) q <= wdata_i;
    end
    assign vnd_bus[i*DW +: DW] = q;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: rdata_o = ctrl_q;
      A_STAT: rdata_o = {1'b0, 4'hF, 5'b0, an_done_i, rf_q, 1'b0, link_up_i, 1'b0, 1'b1};
      A_ID1:  rdata_o = ID1;
      A_ID2:  rdata_o = ID2;
      A_ADV:  rdata_o = adv_q;
      A_LPA:  rdata_o = lp_ability_i;
      A_EXP:  rdata_o = {14'b0, pg_q, lp_an_able_i};
      A_CFG:  rdata_o = cfg_q;
      default: begin
        if (vnd_hit && key) begin
          for (int i = 0; i < int'(VND_N); i++)
            if (vidx == AW'(i)) rdata_o = vnd_bus[i*DW +: DW];
        end
      end
    endcase
  end

  assign soft_rst_o = srst_q;
  assign ctrl_o     = ctrl_q;
  assign adv_o      = adv_q;
  assign cfg_o      = cfg_q;
endmodule

// File: rtl/mdio_mgmt_regs.sv
module mdio_mgmt_regs
  import mdio_pkg::*;
#(
  parameter int unsigned   SYNC_STAGES = 2,
  parameter int unsigned   PRE_LEN     = 32,
  parameter logic [15:0]   ID1         = 16'h00A5,
  parameter logic [15:0]   ID2         = 16'h5C10,
  parameter int unsigned   VND_N       = 5
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        mdc_i,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic [4:0]  phy_addr_i,
  input  logic        link_up_i,
  input  logic        an_done_i,
  input  logic        rfault_set_i,
  input  logic        page_rx_set_i,
  input  logic        lp_an_able_i,
  input  logic [15:0] lp_ability_i,
  output logic        soft_rst_o,
  output logic        loopback_o,
  output logic        an_en_o,
  output logic        force_100_o,
  output logic        force_full_o,
  output logic        power_down_o,
  output logic [15:0] adv_o,
  output logic        rptr_o,
  output logic        bypass_4b5b_o,
  output logic        bypass_scr_o,
  output logic        ldps_o,
  output logic        analog_off_o,
  output logic [1:0]  lb_mode_o
);
  logic          mdc_rise, mdc_fall, mdio_s;
  logic          rd_stb, wr_stb;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] wdata, rdata, ctrl, cfg;

  mdio_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .mdc_i, .mdio_i,
    .rise_o(mdc_rise), .fall_o(mdc_fall), .dat_o(mdio_s)
  );

  mdio_frame #(.PRE_LEN(PRE_LEN)) u_frame (
    .clk_i, .rst_ni,
    .rise_i(mdc_rise), .fall_i(mdc_fall), .dat_i(mdio_s),
    .phy_addr_i, .rdata_i(rdata),
    .rd_stb_o(rd_stb), .wr_stb_o(wr_stb), .addr_o(cmd_addr), .wdata_o(wdata),
    .mdio_o, .mdio_oe_o
  );

  mdio_regs #(.ID1(ID1), .ID2(ID2), .VND_N(VND_N)) u_regs (
    .clk_i, .rst_ni,
    .rd_stb_i(rd_stb), .wr_stb_i(wr_stb), .addr_i(cmd_addr), .wdata_i(wdata),
    .rdata_o(rdata),
    .link_up_i, .an_done_i, .rfault_set_i, .page_rx_set_i, .lp_an_able_i, .lp_ability_i,
    .soft_rst_o, .ctrl_o(ctrl), .adv_o, .cfg_o(cfg)
  );

  assign loopback_o    = ctrl[14];
  assign an_en_o       = ctrl[12];
  assign force_100_o   = ctrl[13] & ~ctrl[12];
  assign force_full_o  = ctrl[8]  & ~ctrl[12];
  assign power_down_o  = ctrl[11];
  assign rptr_o        = cfg[15];
  assign bypass_4b5b_o = cfg[14];
  assign bypass_scr_o  = cfg[13];
  assign ldps_o        = cfg[12];
  assign analog_off_o  = cfg[11];
  assign lb_mode_o     = cfg[9:8];
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mdio_o,
  input logic       mdio_oe_o,
  input logic       soft_rst_o,
  input logic       an_en_o,
  input logic       loopback_o,
  input logic [1:0] lb_mode_o,
  input logic [15:0] adv_o,
  input logic       wr_stb
);
  // R4
  soft_rst_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> !soft_rst_o);

  // R4
  soft_rst_dflt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> (an_en_o && !loopback_o && lb_mode_o == 2'b00 && adv_o == 16'h01E1));

  // R3
  ta_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdio_oe_o) |-> !mdio_o);

  // R1
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stb |=> ($stable(lb_mode_o) && $stable(loopback_o) && $stable(an_en_o) && $stable(adv_o)));
endmodule

bind mdio_mgmt_regs mdio_mgmt_chk u_chk (
  .clk_i, .rst_ni, .mdio_o, .mdio_oe_o, .soft_rst_o, .an_en_o, .loopback_o,
  .lb_mode_o, .adv_o, .wr_stb
);

// File: tb/mdio_mgmt_regs_test.sv
module mdio_mgmt_regs_test;
  localparam int HALF = 8;
  localparam logic [4:0] MYADDR = 5'h0A;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic mdc = 1'b0, m_drv = 1'b1;
  logic mdio_o, mdio_oe, line;
  logic link_up = 1'b0, an_done = 1'b0, rf_set = 1'b0, pg_set = 1'b0, lp_an = 1'b0;
  logic [15:0] lp_ab = 16'h0;
  logic soft_rst, loopback, an_en, f100, ffull, pdown, rptr, bp45, bpscr, ldps, aoff;
  logic [15:0] adv;
  logic [1:0] lbm;

  assign line = mdio_oe ? mdio_o : m_drv;

  mdio_mgmt_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .mdc_i(mdc), .mdio_i(line),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe), .phy_addr_i(MYADDR),
    .link_up_i(link_up), .an_done_i(an_done), .rfault_set_i(rf_set),
    .page_rx_set_i(pg_set), .lp_an_able_i(lp_an), .lp_ability_i(lp_ab),
    .soft_rst_o(soft_rst), .loopback_o(loopback), .an_en_o(an_en),
    .force_100_o(f100), .force_full_o(ffull), .power_down_o(pdown), .adv_o(adv),
    .rptr_o(rptr), .bypass_4b5b_o(bp45), .bypass_scr_o(bpscr), .ldps_o(ldps),
    .analog_off_o(aoff), .lb_mode_o(lbm)
  );

  int n_chk = 0, n_fail = 0;
  int srst_pulses = 0;
  bit done = 0;

  always @(posedge clk) if (soft_rst) srst_pulses++;

  // behavioural reference model
  logic [15:0] m_reg [int];
  bit m_rf = 0, m_pg = 0;

  task automatic model_reset();
    m_reg.delete();
    m_reg[0] = 16'h3100; m_reg[4] = 16'h01E1; m_reg[17] = 16'h0;
    for (int i = 20; i < 25; i++) m_reg[i] = 16'h0;
    m_rf = 0; m_pg = 0;
  endtask

  task automatic model_write(input int a, input logic [15:0] d);
    case (a)
      0: if (d[15]) model_reset(); else m_reg[0] = d & 16'h7900;
      4: m_reg[4] = d & 16'h25FF;
      17: m_reg[17] = d & 16'hFB01;
      default: if (a >= 20 && a < 25 && m_reg[17][0]) m_reg[a] = d;
    endcase
  endtask

  function automatic logic [15:0] model_read(input int a);
    case (a)
      0, 4, 17: return m_reg[a];
      1: return 16'h7801 | (an_done ? 16'h20 : 16'h0) | (m_rf ? 16'h10 : 16'h0) | (link_up ? 16'h4 : 16'h0);
      2: return 16'h00A5;
      3: return 16'h5C10;
      5: return lp_ab;
      6: return {14'b0, m_pg, lp_an};
      default: return (a >= 20 && a < 25 && m_reg[17][0]) ? m_reg[a] : 16'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_outputs(input string req);
    logic [15:0] c, g;
    c = m_reg[0]; g = m_reg[17];
    check(req, {loopback, an_en, f100, ffull, pdown},
          16'({c[14], c[12], c[13] & ~c[12], c[8] & ~c[12], c[11]}));
    check(req, adv, m_reg[4]);
    check(req, {rptr, bp45, bpscr, ldps, aoff, lbm}, 16'({g[15:11], g[9:8]}));
  endtask

  task automatic bit_out(input logic b);
    mdc = 1'b0; m_drv = b;
    repeat (HALF) @(negedge clk);
    mdc = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bit_in(output logic v, output logic oe);
    mdc = 1'b0; m_drv = 1'b1;
    repeat (HALF) @(negedge clk);
    v = line; oe = mdio_oe;
    mdc = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic send_hdr(input int pre, input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra);
    for (int i = 0; i < pre; i++) bit_out(1'b1);
    bit_out(1'b0); bit_out(1'b1);
    for (int i = 1; i >= 0; i--) bit_out(op[i]);
    for (int i = 4; i >= 0; i--) bit_out(pa[i]);
    for (int i = 4; i >= 0; i--) bit_out(ra[i]);
  endtask

  task automatic mdio_wr(input logic [4:0] pa, input int ra, input logic [15:0] d, input int pre = 32);
    send_hdr(pre, 2'b01, pa, 5'(ra));
    bit_out(1'b1); bit_out(1'b0);
    for (int i = 15; i >= 0; i--) bit_out(d[i]);
    bit_out(1'b1);
    if (pa == MYADDR && pre >= 32) model_write(ra, d);
  endtask

  // read; checks turnaround behaviour (R3) or absence of drive (R1)
  task automatic mdio_rd(input logic [4:0] pa, input int ra, output logic [15:0] d);
    logic v, oe, any_oe;
    logic [15:0] exp;
    exp = model_read(ra);
    send_hdr(32, 2'b10, pa, 5'(ra));
    if (pa == MYADDR) begin
      if (ra == 1) m_rf = 0;
      if (ra == 5) m_pg = 0;
    end
    any_oe = 1'b0;
    bit_in(v, oe);
    any_oe |= oe;
    if (pa == MYADDR) check("R3 ta1 released", {15'b0, oe}, 16'h0);
    bit_in(v, oe);
    any_oe |= oe;
    if (pa == MYADDR) check("R3 ta2 driven 0", {14'b0, oe, v}, 16'h2);
    for (int i = 15; i >= 0; i--) begin
      bit_in(v, oe);
      any_oe |= oe;
      d[i] = v;
    end
    bit_in(v, oe);
    if (pa == MYADDR) begin
      check("R3 released after data", {15'b0, oe}, 16'h0);
      check($sformatf("R2 read data reg %0d", ra), d, exp);
    end else begin
      check("R1 foreign read not driven", {15'b0, any_oe | oe}, 16'h0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    model_reset();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // reset state
    check("R5 reset outputs", {15'b0, soft_rst}, 16'h0);
    check_outputs("R5 R6 R8 R10 reset fields");
    check("R3 idle not driven", {15'b0, mdio_oe}, 16'h0);

    mdio_rd(MYADDR, 0, d);   // R5 default 0x3100
    mdio_rd(MYADDR, 2, d);   // R12
    mdio_rd(MYADDR, 3, d);   // R12
    mdio_rd(MYADDR, 9, d);   // R12 unimplemented
    mdio_rd(MYADDR, 30, d);  // R12 unimplemented

    // R6: negotiation off, forced fields follow bits 13 and 8
    mdio_wr(MYADDR, 0, 16'h2100);
    check_outputs("R6 forced 100 full");
    mdio_wr(MYADDR, 0, 16'h0100);
    check_outputs("R6 forced 10 full");
    mdio_wr(MYADDR, 0, 16'h3100);
    check_outputs("R6 an on masks forced");
    mdio_wr(MYADDR, 0, 16'h7FFF);
    check_outputs("R5 all writable ctrl bits");
    mdio_rd(MYADDR, 0, d);   // R5 masked readback

    // R1: foreign address
    mdio_wr(5'h0B, 0, 16'h0000);
    check_outputs("R1 foreign write ignored");
    mdio_rd(5'h03, 0, d);
    mdio_rd(MYADDR, 0, d);

    // R8
    mdio_wr(MYADDR, 4, 16'hFFFF);
    check_outputs("R8 adv writable mask");
    mdio_rd(MYADDR, 4, d);

    // R4: software reset
    srst_pulses = 0;
    mdio_wr(MYADDR, 0, 16'h8000);
    check("R4 one reset pulse", 16'(srst_pulses), 16'h1);
    check_outputs("R4 defaults restored");
    mdio_rd(MYADDR, 0, d);
    mdio_rd(MYADDR, 4, d);

    // R7
    link_up = 1'b1; an_done = 1'b1;
    mdio_rd(MYADDR, 1, d);
    @(negedge clk) rf_set = 1'b1;
    @(negedge clk) rf_set = 1'b0;
    m_rf = 1;
    mdio_rd(MYADDR, 1, d);   // R7 fault seen, then cleared
    mdio_rd(MYADDR, 1, d);   // R7 cleared on read
    link_up = 1'b0;
    mdio_rd(MYADDR, 1, d);

    // R9
    lp_ab = 16'h45E1; lp_an = 1'b1;
    @(negedge clk) pg_set = 1'b1;
    @(negedge clk) pg_set = 1'b0;
    m_pg = 1;
    mdio_rd(MYADDR, 6, d);   // R9 set
    mdio_rd(MYADDR, 1, d);
    mdio_rd(MYADDR, 6, d);   // R9 other reads keep it
    mdio_rd(MYADDR, 5, d);   // R9 partner ability, clears page flag
    mdio_rd(MYADDR, 6, d);   // R9 cleared

    // R10
    mdio_wr(MYADDR, 17, 16'hFFFF);
    check_outputs("R10 all cfg controls");
    mdio_rd(MYADDR, 17, d);
    mdio_wr(MYADDR, 17, 16'h0100);
    check_outputs("R10 lb mode 01");
    mdio_wr(MYADDR, 17, 16'h0200);
    check_outputs("R10 lb mode 10");

    // R11 vendor window (key is 0 now)
    mdio_wr(MYADDR, 20, 16'h1234);
    mdio_rd(MYADDR, 20, d);  // R11 locked reads 0
    mdio_wr(MYADDR, 17, 16'h0001);
    mdio_rd(MYADDR, 20, d);  // R11 locked write ignored
    mdio_wr(MYADDR, 22, 16'hBEEF);
    mdio_wr(MYADDR, 24, 16'h5555);
    mdio_rd(MYADDR, 22, d);
    mdio_rd(MYADDR, 24, d);
    mdio_wr(MYADDR, 17, 16'h0000);
    mdio_rd(MYADDR, 22, d);  // R11 locked reads 0
    mdio_wr(MYADDR, 17, 16'h0001);
    mdio_rd(MYADDR, 22, d);  // R11 contents kept
    mdio_rd(MYADDR, 25, d);  // R12 past window

    // R2: short preamble frame is ignored
    for (int i = 0; i < 4; i++) bit_out(1'b0);
    mdio_wr(MYADDR, 17, 16'hFB00, 20);
    check_outputs("R2 short preamble ignored");
    mdio_rd(MYADDR, 17, d);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule